// File: doc/BRIEF.md
# Block Address Translation Unit

This unit translates a 32-bit effective address into a real address by comparing it against a small set of block-mapping entries, each of which covers one naturally aligned region between 128 KB and 256 MB. There are two independent sets of entries. Instruction fetches search only the instruction set, while loads and stores search only the data set. Privileged software programs each entry as a pair of 32-bit words, an upper word and a lower word, through a simple write port.

A lookup is purely combinational from the stored entries. In the same cycle it reports whether a block hit occurred, the translated real address, the storage-mode bits, the protection bits and any protection fault. A hit tells the surrounding page-translation logic that the block mapping overrides it. A variable-length mask in each entry sets the block size. That mask removes the low effective-page bits from the comparison and merges the same bits into the real page number.

Top module: `bat_xlate`

## Requirements
- R1: There are four entries for instruction translation and four for data translation. A lookup with `acc_fetch`=1 searches only the instruction entries, and a lookup with `acc_fetch`=0 searches only the data entries.
- R2: An entry can match only when (Vs AND NOT `priv_user`) OR (Vp AND `priv_user`) is true. Vs and Vp are the enable bits of the upper word.
- R3: Upper-word fields (bit 31 = MSB): effective page index in [31:17], length mask in [12:2], Vs in [1], Vp in [0]. Lower-word fields: real page number in [31:17], storage mode W,I,M,G in [6:3] (W at bit 6, G at bit 3), protection in [1:0]. All other bits are ignored.
- R4: An entry matches when `ea[31:28]` equals index bits [14:11] and (`ea[27:17]` AND NOT mask) equals index bits [10:0].
- R5: On an accepted hit, `ra` = {real page [14:11], real page [10:0] OR (`ea[27:17]` AND mask), `ea[16:0]`}.
- R6: On a hit, `hit` and `override` are 1, and `pp_out` carries the entry's protection bits. With no hit, or with `acc_valid`=0, `hit`, `override`, `ra`, `wimg`, `pp_out`, `multi_hit` and both fault outputs are 0.
- R7: A hit in an instruction entry reports `wimg` = {W,I,M,0}. A hit in a data entry reports all four stored bits. `wimg[3]` is W and `wimg[0]` is G.
- R8: Protection 00 denies every access. Protection 01 and 11 allow reads only. Protection 10 allows reads and writes. Fetches count as reads. A denied hit raises `ifetch_fault` for a fetch and `data_fault` otherwise, and it drives `ra` to 0.
- R9: When more than one entry of the searched set matches, the lowest-numbered entry supplies the result and `multi_hit` is 1.
- R10: A write with `wr_en`=1 updates the entry on the next rising clock edge. Lookups made before that edge still see the old contents.
- R11: After reset, every entry is cleared, so no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_iset | input | 1 | 1 selects the instruction set, 0 the data set |
| wr_idx | input | 2 | Entry number |
| wr_lower | input | 1 | 1 writes the lower word, 0 the upper word |
| wr_data | input | 32 | Word to store |
| acc_valid | input | 1 | A lookup is requested |
| acc_fetch | input | 1 | Lookup is an instruction fetch |
| acc_write | input | 1 | Lookup is a store (ignored for fetches) |
| priv_user | input | 1 | Processor is in problem (user) state |
| ea | input | 32 | Effective address |
| hit | output | 1 | A valid entry matched |
| override | output | 1 | Block mapping overrides page translation |
| multi_hit | output | 1 | More than one entry matched |
| ra | output | 32 | Real address, 0 on miss or fault |
| wimg | output | 4 | Storage-mode bits of the hit entry |
| pp_out | output | 2 | Protection bits of the hit entry |
| ifetch_fault | output | 1 | Instruction-storage protection fault |
| data_fault | output | 1 | Data-storage protection fault |

## Verification
All lookup results depend combinationally on the inputs and the stored entries. The bench applies each lookup on a falling edge and samples 1 ns later, inside the same clock period. A write is the only registered path and takes effect one rising edge later. The write-timing check therefore samples once before that edge, expecting the old result, and once after it, expecting the new result. Every other scenario completes its writes before it starts the lookups it checks.

// File: rtl/bat_xlate.sv
module bat_xlate #(
  parameter int NENT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_iset,
  input  logic [1:0]  wr_idx,
  input  logic        wr_lower,
  input  logic [31:0] wr_data,
  input  logic        acc_valid,
  input  logic        acc_fetch,
  input  logic        acc_write,
  input  logic        priv_user,
  input  logic [31:0] ea,
  output logic        hit,
  output logic        override,
  output logic        multi_hit,
  output logic [31:0] ra,
  output logic [3:0]  wimg,
  output logic [1:0]  pp_out,
  output logic        ifetch_fault,
  output logic        data_fault
);
  localparam logic [31:0] UP_KEEP = 32'hFFFE_1FFF;
  localparam logic [31:0] LO_KEEP = 32'hFFFE_007B;

  logic [31:0] i_up [NENT];
  logic [31:0] i_lo [NENT];
  logic [31:0] d_up [NENT];
  logic [31:0] d_lo [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NENT; k++) begin
        i_up[k] <= '0;
        i_lo[k] <= '0;
        d_up[k] <= '0;
        d_lo[k] <= '0;
      end
    end else if (wr_en) begin
      for (int k = 0; k < NENT; k++) begin
        if (wr_idx == k[1:0]) begin
          if (wr_iset && !wr_lower)  i_up[k] <= wr_data & UP_KEEP;
          if (wr_iset && wr_lower)   i_lo[k] <= wr_data & LO_KEEP;
          if (!wr_iset && !wr_lower) d_up[k] <= wr_data & UP_KEEP;
          if (!wr_iset && wr_lower)  d_lo[k] <= wr_data & LO_KEEP;
        end
      end
    end
  end

  logic [NENT-1:0] match;
  logic [31:0]     sel_up [NENT];
  logic [31:0]     sel_lo [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic [10:0] bl;
    logic        en;
    assign sel_up[g] = acc_fetch ? i_up[g] : d_up[g];
    assign sel_lo[g] = acc_fetch ? i_lo[g] : d_lo[g];
    assign bl        = sel_up[g][12:2];
    assign en        = (sel_up[g][1] & ~priv_user) | (sel_up[g][0] & priv_user);
    assign match[g]  = acc_valid & en
                     & (ea[31:28] == sel_up[g][31:28])
                     & ((ea[27:17] & ~bl) == sel_up[g][27:17]);
  end

  logic [31:0] w_up, w_lo;
  always_comb begin
    w_up = '0;
    w_lo = '0;
    for (int k = NENT - 1; k >= 0; k--) begin
      if (match[k]) begin
        w_up = sel_up[k];
        w_lo = sel_lo[k];
      end
    end
  end

  logic [1:0]  pp_w;
  logic        deny;
  logic [10:0] w_bl;

  assign hit       = |match;
  assign override  = hit;
  assign multi_hit = $countones(match) > 1;
  assign pp_w      = w_lo[1:0];
  assign w_bl      = w_up[12:2];
  assign deny      = hit & ((pp_w == 2'b00) | ((pp_w != 2'b10) & acc_write & ~acc_fetch));

  assign ra = (hit && !deny)
            ? {w_lo[31:28], w_lo[27:17] | (ea[27:17] & w_bl), ea[16:0]}
            : 32'h0;
  assign wimg         = hit ? {w_lo[6:4], w_lo[3] & ~acc_fetch} : 4'h0;
  assign pp_out       = hit ? pp_w : 2'b00;
  assign ifetch_fault = deny & acc_fetch;
  assign data_fault   = deny & ~acc_fetch;
endmodule

module bat_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_fetch,
  input logic [31:0] ea,
  input logic        hit,
  input logic        multi_hit,
  input logic [31:0] ra,
  input logic [3:0]  wimg,
  input logic        ifetch_fault,
  input logic        data_fault
);
  // R8
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifetch_fault && data_fault));
  // R8
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch_fault || data_fault) |-> (hit && ra == 32'h0));
  // R8
  fault_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch_fault |-> acc_fetch) and (data_fault |-> !acc_fetch));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!hit && !multi_hit && ra == 32'h0));
  // R7
  fetch_unguarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && acc_fetch) |-> !wimg[0]);
  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ifetch_fault && !data_fault) |-> (ra[16:0] == ea[16:0]));
  // R9
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> hit);
endmodule

bind bat_xlate bat_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fetch(acc_fetch),
  .ea(ea), .hit(hit), .multi_hit(multi_hit), .ra(ra), .wimg(wimg),
  .ifetch_fault(ifetch_fault), .data_fault(data_fault)
);

// File: tb/tb_bat_xlate.sv
module tb_bat_xlate;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_iset = 0, wr_lower = 0;
  logic [1:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic acc_valid = 0, acc_fetch = 0, acc_write = 0, priv_user = 0;
  logic [31:0] ea = 0;
  logic hit, override, multi_hit, ifetch_fault, data_fault;
  logic [31:0] ra;
  logic [3:0] wimg;
  logic [1:0] pp_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bat_xlate dut (.*);

  function automatic logic [31:0] mk_up(input logic [14:0] bepi, input logic [10:0] bl,
                                        input logic vs, input logic vp);
    return {bepi, 4'b0, bl, vs, vp};
  endfunction
  function automatic logic [31:0] mk_lo(input logic [14:0] brpn, input logic [3:0] wm,
                                        input logic [1:0] pp);
    return {brpn, 10'b0, wm, 1'b0, pp};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit iset, input int idx, input bit lower, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_iset = iset; wr_idx = idx[1:0]; wr_lower = lower; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input bit f, input bit w, input bit u, input logic [31:0] a);
    @(negedge clk);
    acc_valid = 1; acc_fetch = f; acc_write = w; priv_user = u; ea = a;
    #1;
  endtask

  task automatic t_reset;
    look(0, 0, 0, 32'h1234_5678);
    chk("R11 hit after reset", {31'b0, hit}, 0);
    look(1, 0, 1, 32'h0000_0000);
    chk("R11 fetch hit after reset", {31'b0, hit}, 0);
  endtask

  task automatic t_write_timing;
    wr(0, 1, 1, mk_lo(15'h22B0, 4'b0101, 2'b10));
    @(negedge clk);
    wr_en = 1; wr_iset = 0; wr_idx = 1; wr_lower = 0;
    wr_data = mk_up(15'h0918, 11'h007, 1, 0) | 32'h0001_E000;
    acc_valid = 1; acc_fetch = 0; acc_write = 0; priv_user = 0; ea = 32'h123A_BCDE;
    #1;
    chk("R10 old contents before edge", {31'b0, hit}, 0);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R10 new contents after edge", {31'b0, hit}, 1);
  endtask

  task automatic t_data_hit;
    look(0, 0, 0, 32'h123A_BCDE);
    chk("R5 ra 1MB block", ra, 32'h456A_BCDE);
    chk("R6 override", {31'b0, override}, 1);
    chk("R7 data wimg", {28'b0, wimg}, 4'b0101);
    chk("R6 pp_out", {30'b0, pp_out}, 2'b10);
    chk("R9 no multi", {31'b0, multi_hit}, 0);
    look(0, 1, 0, 32'h1230_0000);
    chk("R8 pp10 store allowed", ra, 32'h4560_0000);
    chk("R3 reserved upper bits ignored", {31'b0, hit}, 1);
  endtask

  task automatic t_miss;
    look(0, 0, 0, 32'h1240_0000);
    chk("R4 just past block", {31'b0, hit}, 0);
    chk("R6 miss ra zero", ra, 0);
    chk("R6 miss wimg zero", {28'b0, wimg}, 0);
    look(0, 0, 0, 32'h2230_0000);
    chk("R4 top bits compared", {31'b0, hit}, 0);
    look(1, 0, 0, 32'h123A_BCDE);
    chk("R1 fetch ignores data set", {31'b0, hit}, 0);
    @(negedge clk); acc_valid = 0; acc_fetch = 0; ea = 32'h123A_BCDE; #1;
    chk("R6 no request no hit", {31'b0, hit}, 0);
  endtask

  task automatic t_priv;
    look(0, 0, 1, 32'h123A_BCDE);
    chk("R2 user vs supervisor-only", {31'b0, hit}, 0);
    wr(0, 0, 0, mk_up(15'h0800, 11'h000, 0, 1));
    wr(0, 0, 1, mk_lo(15'h0010, 4'b0000, 2'b01));
    look(0, 0, 1, 32'h1001_2345);
    chk("R2 user-only entry user", ra, 32'h0021_2345);
    look(0, 0, 0, 32'h1001_2345);
    chk("R2 user-only entry supervisor", {31'b0, hit}, 0);
  endtask

  task automatic t_protect;
    look(0, 1, 1, 32'h1001_2345);
    chk("R8 pp01 store fault", {31'b0, data_fault}, 1);
    chk("R8 fault ra zero", ra, 0);
    chk("R8 fault keeps hit", {31'b0, hit}, 1);
    chk("R8 no ifetch fault", {31'b0, ifetch_fault}, 0);
    wr(0, 0, 1, mk_lo(15'h0010, 4'b0000, 2'b11));
    look(0, 1, 1, 32'h1001_2345);
    chk("R8 pp11 store fault", {31'b0, data_fault}, 1);
    look(0, 0, 1, 32'h1001_2345);
    chk("R8 pp11 load ok", {31'b0, data_fault}, 0);
    wr(0, 0, 1, mk_lo(15'h0010, 4'b0000, 2'b00));
    look(0, 0, 1, 32'h1001_2345);
    chk("R8 pp00 load fault", {31'b0, data_fault}, 1);
  endtask

  task automatic t_instr;
    wr(1, 2, 0, mk_up(15'h3800, 11'h7FF, 1, 1));
    wr(1, 2, 1, mk_lo(15'h5000, 4'b1111, 2'b01));
    look(1, 1, 0, 32'h7ABC_DEF0);
    chk("R5 ra 256MB block", ra, 32'hAABC_DEF0);
    chk("R7 fetch G reads 0", {28'b0, wimg}, 4'b1110);
    chk("R8 fetch is read", {31'b0, ifetch_fault}, 0);
    look(0, 0, 0, 32'h7ABC_DEF0);
    chk("R1 load ignores instr set", {31'b0, hit}, 0);
    wr(1, 2, 1, mk_lo(15'h5000, 4'b1111, 2'b00));
    look(1, 0, 1, 32'h7ABC_DEF0);
    chk("R8 fetch pp00 fault", {31'b0, ifetch_fault}, 1);
    chk("R8 fetch fault not data", {31'b0, data_fault}, 0);
  endtask

  task automatic t_multi;
    wr(0, 3, 0, mk_up(15'h2000, 11'h000, 1, 0));
    wr(0, 3, 1, mk_lo(15'h0300, 4'b0000, 2'b10));
    wr(0, 2, 0, mk_up(15'h2000, 11'h003, 1, 0));
    wr(0, 2, 1, mk_lo(15'h0200, 4'b1000, 2'b10));
    look(0, 0, 0, 32'h4001_0004);
    chk("R9 lowest entry wins", ra, 32'h0401_0004);
    chk("R9 multi flag", {31'b0, multi_hit}, 1);
    look(0, 0, 0, 32'h4004_0004);
    chk("R9 single match no flag", {31'b0, multi_hit}, 0);
    chk("R5 mask ORs page bits", ra, 32'h0404_0004);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_write_timing;
    t_data_hit;
    t_miss;
    t_priv;
    t_protect;
    t_instr;
    t_multi;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule